// File: doc/BRIEF.md
# Display Configuration and LED Latch Register Block

This block holds the configuration state of a dot-matrix LCD controller with key scanning and LED outputs. A serial front end decodes each incoming byte and classifies it. The front end then raises exactly one of five write strobes for one clock, with the byte on a shared bus. The strobes mark a display-mode byte, a run-status byte, an LED latch byte, a character-address byte or a font-data byte. The block applies each byte to its registers, including the side effects that a mode change has on the run flags. It drives the mode bits, the run flags, the LED sink enables and a one-cycle font write port toward the character-generator memory.

Changing the display mode always leaves the panel dark, the LEDs allowed and key scanning halted. A status byte must follow before the display runs again. A mode byte that repeats the present mode leaves everything untouched. Font bytes carry their own row number in the top three bits, so the character they belong to must already have been chosen with an address byte.

Top module: `lcdc_cfg_regs`

## Requirements
- R1: After the active-low reset, the block is in the power-on state: 1/8 duty, master, external supply, LCD off, LED enable on, key scan stopped, LED latch zero, character target 0 valid, and no font strobe.
- R2: A mode byte sets duty from bit 0 (0 = 1/8, 1 = 1/15), slave from bit 1 (0 = master) and internal supply from bit 2 (0 = external). Bits 7..3 have no effect.
- R3: A mode byte whose three mode bits differ from the current mode also clears LCD on, sets LED enable and clears key scan run, in the same clock.
- R4: A mode byte equal to the current mode changes no mode bit and no run flag.
- R5: A status byte sets LCD on from bit 0, LED enable from bit 1 and key scan run from bit 2. Bits 7..3 have no effect, and the mode bits are untouched.
- R6: An LED byte loads bits 3..0 into the latch and ignores bits 7..4. LED sink enable i is asserted exactly when latch bit i and LED enable are both 1.
- R7: An address byte below 10h makes its low four bits the font target. An address byte of 10h or more leaves no valid target, and later font bytes then raise no strobe until a valid address byte arrives.
- R8: A font byte with a valid target and a row field (bits 7..5) of 0 to 6 raises the font strobe for exactly one cycle. The strobe appears in the cycle after the byte and carries the target character, the row field and the dot bits 4..0. At all other times the strobe is low.
- R9: A font byte whose row field is 7 raises no strobe.
- R10: The high display-position enable is 1 in 1/8 duty and 0 in 1/15 duty, which disables positions 61 to 64.
- R11: At most one write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | Bus byte is a display-mode byte |
| stat_wr | input | 1 | Bus byte is a run-status byte |
| led_wr | input | 1 | Bus byte is an LED latch byte |
| addr_wr | input | 1 | Bus byte is a character address |
| font_wr | input | 1 | Bus byte is a font row |
| wr_byte | input | 8 | Shared decoded data byte |
| duty_15 | output | 1 | 1 = 1/15 duty, shared pins act as commons |
| slave_mode | output | 1 | 1 = slave |
| int_supply | output | 1 | 1 = internal drive voltage |
| lcd_on | output | 1 | Display running |
| led_enable | output | 1 | LED outputs allowed |
| key_scan_run | output | 1 | Key scanning running |
| hi_pos_en | output | 1 | Display positions 61-64 enabled |
| led_drive | output | 4 | Open-drain LED sink enables |
| cg_we | output | 1 | Font write strobe |
| cg_char | output | 4 | Font write character |
| cg_row | output | 3 | Font write row |
| cg_dots | output | 5 | Font write dot data |

## Verification
A wrong mode or run register shows on the mode and run outputs in the very next cycle after the byte that set it. It also shows through led_drive, because LED enable gates every sink. A wrong character target or validity flag stays hidden until the next font byte, and then shows as a missing strobe, a spurious strobe or a wrong cg_char. The bench therefore writes font bytes after every kind of address byte. A lost or added mode side effect is exposed by mode bytes written after random status bytes, so that the run flags have something to lose.

// File: rtl/lcdc_cfg_pkg.sv
package lcdc_cfg_pkg;

    typedef logic [7:0] cfg_byte_t;

    // bit positions inside the mode and status bytes
    localparam int MODE_DUTY_BIT  = 0;
    localparam int MODE_SLAVE_BIT = 1;
    localparam int MODE_SUP_BIT   = 2;
    localparam int RUN_LCD_BIT    = 0;
    localparam int RUN_LED_BIT    = 1;
    localparam int RUN_KEY_BIT    = 2;

    typedef struct packed {
        logic duty15;
        logic slave;
        logic int_sup;
    } mode_t;

    typedef struct packed {
        logic lcd_on;
        logic led_en;
        logic key_run;
    } run_t;

    localparam mode_t MODE_POR = '{duty15: 1'b0, slave: 1'b0, int_sup: 1'b0};
    // run flags left behind by reset and by any mode change
    localparam run_t  RUN_IDLE = '{lcd_on: 1'b0, led_en: 1'b1, key_run: 1'b0};

    function automatic mode_t decode_mode(input cfg_byte_t b);
        mode_t m;
        m.duty15  = b[MODE_DUTY_BIT];
        m.slave   = b[MODE_SLAVE_BIT];
        m.int_sup = b[MODE_SUP_BIT];
        return m;
    endfunction

    function automatic run_t decode_run(input cfg_byte_t b);
        run_t r;
        r.lcd_on  = b[RUN_LCD_BIT];
        r.led_en  = b[RUN_LED_BIT];
        r.key_run = b[RUN_KEY_BIT];
        return r;
    endfunction

endpackage

// File: rtl/lcdc_mode_reg.sv
module lcdc_mode_reg
    import lcdc_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_wr,
    input  logic      stat_wr,
    input  cfg_byte_t wr_byte,
    output mode_t     mode_o,
    output run_t      run_o
);

    typedef struct packed {
        mode_t mode;
        run_t  run;
    } state_t;

    state_t st_d, st_q;
    mode_t  req_mode;

    always_comb begin
        st_d     = st_q;
        req_mode = decode_mode(wr_byte);
        if (mode_wr) begin
            if (req_mode != st_q.mode) begin
                st_d.mode = req_mode;
                st_d.run  = RUN_IDLE;
            end
        end else if (stat_wr) begin
            st_d.run = decode_run(wr_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_POR;
            st_q.run  <= RUN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign run_o  = st_q.run;

    // R3
    mode_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && decode_mode(wr_byte) != st_q.mode)
        |=> (!run_o.lcd_on && run_o.led_en && !run_o.key_run));

    // R4
    same_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && decode_mode(wr_byte) == st_q.mode) |=> $stable(st_q));

    // R5
    stat_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> $stable(mode_o));

endmodule

// File: rtl/lcdc_led_latch.sv
module lcdc_led_latch
    import lcdc_cfg_pkg::*;
#(
    parameter int LED_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               led_wr,
    input  cfg_byte_t          wr_byte,
    input  logic               led_en,
    output logic [LED_CNT-1:0] led_drive
);

    logic [LED_CNT-1:0] latch_d, latch_q;

    always_comb begin
        latch_d = latch_q;
        if (led_wr) begin
            latch_d = wr_byte[LED_CNT-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    for (genvar i = 0; i < LED_CNT; i++) begin : g_sink
        assign led_drive[i] = latch_q[i] & led_en;
    end

    // R6
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !led_wr |=> $stable(latch_q));

endmodule

// File: rtl/lcdc_cg_writer.sv
module lcdc_cg_writer
    import lcdc_cfg_pkg::*;
#(
    parameter int CG_CHARS = 16,
    parameter int DOT_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          addr_wr,
    input  logic                          font_wr,
    input  cfg_byte_t                     wr_byte,
    output logic                          cg_we,
    output logic [$clog2(CG_CHARS)-1:0]   cg_char,
    output logic [$bits(cfg_byte_t)-DOT_W-1:0] cg_row,
    output logic [DOT_W-1:0]              cg_dots
);

    localparam int BYTE_W   = $bits(cfg_byte_t);
    localparam int CHAR_W   = $clog2(CG_CHARS);
    localparam int ROW_W    = BYTE_W - DOT_W;
    localparam logic [ROW_W-1:0]  ROW_SKIP  = '1;
    localparam logic [BYTE_W-1:0] CHAR_LIM  = BYTE_W'(CG_CHARS);

    typedef struct packed {
        logic [CHAR_W-1:0] chr;
        logic              tgt_ok;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [DOT_W-1:0]  dots;
    } cg_state_t;

    cg_state_t cg_d, cg_q;
    logic [ROW_W-1:0] row_in;

    always_comb begin
        cg_d    = cg_q;
        cg_d.we = 1'b0;
        row_in  = wr_byte[BYTE_W-1 -: ROW_W];
        if (addr_wr) begin
            cg_d.chr    = wr_byte[CHAR_W-1:0];
            cg_d.tgt_ok = (wr_byte < CHAR_LIM);
        end else if (font_wr && cg_q.tgt_ok && row_in != ROW_SKIP) begin
            cg_d.we   = 1'b1;
            cg_d.row  = row_in;
            cg_d.dots = wr_byte[DOT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cg_q.chr    <= '0;
            cg_q.tgt_ok <= 1'b1;
            cg_q.we     <= 1'b0;
            cg_q.row    <= '0;
            cg_q.dots   <= '0;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign cg_we   = cg_q.we;
    assign cg_char = cg_q.chr;
    assign cg_row  = cg_q.row;
    assign cg_dots = cg_q.dots;

    // R9
    row_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (font_wr && wr_byte[BYTE_W-1 -: ROW_W] == ROW_SKIP) |=> !cg_we);

    // R8
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !font_wr |=> !cg_we);

    // R7
    bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wr_byte >= CHAR_LIM) ##1 font_wr |=> !cg_we);

endmodule

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
    import lcdc_cfg_pkg::*;
#(
    parameter int LED_CNT  = 4,
    parameter int CG_CHARS = 16,
    parameter int DOT_W    = 5,
    localparam int CHAR_W  = $clog2(CG_CHARS),
    localparam int ROW_W   = $bits(cfg_byte_t) - DOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic               stat_wr,
    input  logic               led_wr,
    input  logic               addr_wr,
    input  logic               font_wr,
    input  logic [7:0]         wr_byte,
    output logic               duty_15,
    output logic               slave_mode,
    output logic               int_supply,
    output logic               lcd_on,
    output logic               led_enable,
    output logic               key_scan_run,
    output logic               hi_pos_en,
    output logic [LED_CNT-1:0] led_drive,
    output logic               cg_we,
    output logic [CHAR_W-1:0]  cg_char,
    output logic [ROW_W-1:0]   cg_row,
    output logic [DOT_W-1:0]   cg_dots
);

    mode_t mode;
    run_t  run;

    lcdc_mode_reg i_mode_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .stat_wr (stat_wr),
        .wr_byte (wr_byte),
        .mode_o  (mode),
        .run_o   (run)
    );

    lcdc_led_latch #(.LED_CNT(LED_CNT)) i_led_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_wr    (led_wr),
        .wr_byte   (wr_byte),
        .led_en    (run.led_en),
        .led_drive (led_drive)
    );

    lcdc_cg_writer #(.CG_CHARS(CG_CHARS), .DOT_W(DOT_W)) i_cg_writer (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (addr_wr),
        .font_wr (font_wr),
        .wr_byte (wr_byte),
        .cg_we   (cg_we),
        .cg_char (cg_char),
        .cg_row  (cg_row),
        .cg_dots (cg_dots)
    );

    assign duty_15      = mode.duty15;
    assign slave_mode   = mode.slave;
    assign int_supply   = mode.int_sup;
    assign lcd_on       = run.lcd_on;
    assign led_enable   = run.led_en;
    assign key_scan_run = run.key_run;
    assign hi_pos_en    = ~mode.duty15;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_wr, stat_wr, led_wr, addr_wr, font_wr}));

    // R6
    led_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !led_enable |-> (led_drive == '0));

endmodule

// File: tb/test_lcdc_cfg_regs.sv
module test_lcdc_cfg_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 0, stat_wr = 0, led_wr = 0, addr_wr = 0, font_wr = 0;
    logic [7:0] wr_byte = '0;
    logic       duty_15, slave_mode, int_supply, lcd_on, led_enable, key_scan_run, hi_pos_en;
    logic [3:0] led_drive;
    logic       cg_we;
    logic [3:0] cg_char;
    logic [2:0] cg_row;
    logic [4:0] cg_dots;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    logic [2:0] m_mode;   // {int_sup, slave, duty}
    logic [2:0] m_run;    // {key, led_en, lcd}
    logic [3:0] m_latch;
    logic [3:0] m_char;
    logic       m_ok;
    logic       e_we;
    logic [2:0] e_row;
    logic [4:0] e_dots;

    always #10 clk = ~clk;

    lcdc_cfg_regs i_lcdc_cfg_regs (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .stat_wr(stat_wr), .led_wr(led_wr),
        .addr_wr(addr_wr), .font_wr(font_wr), .wr_byte(wr_byte),
        .duty_15(duty_15), .slave_mode(slave_mode), .int_supply(int_supply),
        .lcd_on(lcd_on), .led_enable(led_enable), .key_scan_run(key_scan_run),
        .hi_pos_en(hi_pos_en), .led_drive(led_drive),
        .cg_we(cg_we), .cg_char(cg_char), .cg_row(cg_row), .cg_dots(cg_dots)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_drive();
        return m_latch & {4{m_run[1]}};
    endfunction

    task automatic check_all(input string ctx);
        chk({ctx, " R2 mode"}, {int_supply, slave_mode, duty_15}, m_mode);
        chk({ctx, " R5 run"}, {key_scan_run, led_enable, lcd_on}, m_run);
        chk({ctx, " R6 led"}, led_drive, exp_drive());
        chk({ctx, " R10 hipos"}, hi_pos_en, !m_mode[0]);
        chk({ctx, " R8 we"}, cg_we, e_we);
        if (e_we) begin
            chk({ctx, " R8 char"}, cg_char, m_char);
            chk({ctx, " R8 row"}, cg_row, e_row);
            chk({ctx, " R8 dots"}, cg_dots, e_dots);
        end
    endtask

    task automatic model_reset();
        m_mode = 3'b000; m_run = 3'b010; m_latch = '0;
        m_char = '0; m_ok = 1'b1; e_we = 1'b0; e_row = '0; e_dots = '0;
    endtask

    // kind: 0 mode, 1 status, 2 led, 3 addr, 4 font, 5 idle
    task automatic op(input int kind, input logic [7:0] b, input string ctx);
        @(negedge clk);
        wr_byte = b;
        mode_wr = (kind == 0); stat_wr = (kind == 1); led_wr = (kind == 2);
        addr_wr = (kind == 3); font_wr = (kind == 4);
        @(posedge clk);
        @(negedge clk);
        {mode_wr, stat_wr, led_wr, addr_wr, font_wr} = '0;
        e_we = 1'b0;
        case (kind)
            0: if (b[2:0] != m_mode) begin m_mode = b[2:0]; m_run = 3'b010; end
            1: m_run = b[2:0];
            2: m_latch = b[3:0];
            3: begin m_char = b[3:0]; m_ok = (b < 8'h10); end
            4: if (m_ok && b[7:5] != 3'd7) begin e_we = 1'b1; e_row = b[7:5]; e_dots = b[4:0]; end
            default: ;
        endcase
        check_all(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_all("R1 reset");
        rst_n = 1'b1;

        // R1 font to default target char 0
        op(4, 8'b010_10101, "R1 default target");
        // R2 / R3: mode change with high bits set, after running status
        op(1, 8'hF7, "R5 status all on");
        op(0, 8'hF9, "R3 mode change");
        // R4: same mode leaves run flags
        op(1, 8'h05, "R5 lcd+key on, led off");
        op(0, 8'h01, "R4 same mode");
        op(0, 8'hF9, "R4 same mode high bits");
        // R6: high nibble ignored, gating
        op(2, 8'hA6, "R6 latch");
        op(1, 8'h02, "R6 led enable");
        op(1, 8'h00, "R6 led disable");
        op(0, 8'h06, "R3 mode change reenables leds");
        // R10 both duties
        op(0, 8'h07, "R10 1/15");
        op(0, 8'h00, "R10 1/8");
        // R7 / R8 / R9 font path
        op(3, 8'h0F, "R7 addr 0F");
        op(4, 8'b110_11111, "R8 row 6");
        op(5, 8'h00, "R8 strobe one cycle");
        op(4, 8'b111_10101, "R9 row 7");
        op(3, 8'h10, "R7 addr 10");
        op(4, 8'b000_00001, "R7 no target");
        op(3, 8'hFF, "R7 addr FF");
        op(4, 8'b011_01010, "R7 still no target");
        op(3, 8'h03, "R7 valid again");
        op(4, 8'b000_11011, "R8 row 0");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            logic [7:0] b;
            k = $urandom_range(0, 5);
            b = 8'($urandom());
            if (k == 3 && $urandom_range(0, 3) != 0) b[7:4] = 4'h0;
            op(k, b, "rand");
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule